// File: doc/BRIEF.md
# Status Channel Synchronization Controller

This block brings up and supervises the transmit side of a packet link that gets its flow control back over a 2-bit status channel. It watches the incoming status stream for framing words. It checks each status sequence against a 2-bit diagonal parity code (DIP-2), and on that basis decides whether the link is in sync. It also picks what the 16-bit transmit data bus carries: idle words, training words or user data taken from the transmit FIFO. While the link is out of sync, every channel is reported to the user side as "satisfied", so no new traffic is started.

The controller has three states. RESET is held while the active-low reset is low. The transition RESET→HUNT is taken on the first clock edge after reset is released. HUNT→SYNC is taken when the required run of good parity checks has been seen. SYNC→HUNT is taken on framing loss, on a run of parity errors, or when enable is dropped. Both HUNT and SYNC go back to RESET at once, without waiting for a clock edge, when reset is asserted. A status sequence has a fixed layout: one or more framing words "11", then `NUM_CH` calendar words (channel 0 first), then one parity word. A sequence starts at the first non-"11" word that follows a framing word.

Top module: `stat_sync_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in RESET, with no clock needed. In this state `in_sync` is 0, `tx_kind` is 0 (idle), `tx_data` equals `IDLE_WORD`, `fifo_rd` is 0, and `user_stat` holds "10" in every 2-bit field.
- R2: On the first clock edge after `rst_n` rises, the block enters HUNT. In HUNT, `tx_kind` is 1 (training), `tx_data` equals `TRAIN_WORD`, `fifo_rd` is 0, and `user_stat` holds "10" in every field.
- R3: While `src_en` is low in HUNT, the block never enters SYNC, and its good-check count is held at zero.
- R4: Parity rule. A sequence starts at a non-"11" word that directly follows a "11" word. The accumulator starts at "11". For each calendar word w it becomes {acc[0],acc[1]} XOR w. The word after calendar entry `NUM_CH-1` is compared with the accumulator. HUNT→SYNC occurs at the edge that samples the `MATCH_CNT`-th consecutive good parity word while `src_en` is high. Any bad parity word resets that run to zero.
- R5: In SYNC, `user_stat[2k+1:2k]` takes calendar word k at the clock edge that samples that word, and holds it until the next update.
- R6: In SYNC, `tx_kind` is 1 (training) for one cycle in every `TRAIN_PERIOD` cycles, on cycle index `TRAIN_PERIOD-1`, counting from 0 at SYNC entry. On the other SYNC cycles, if `fifo_vld` is high, `tx_kind` is 2 (data), `tx_data` equals `fifo_data` and `fifo_rd` is 1. Otherwise `tx_kind` is idle.
- R7: In SYNC, the fourth consecutive "11" word causes SYNC→HUNT at the edge that samples it. Three consecutive "11" words do not.
- R8: In SYNC, the `ERR_CNT`-th consecutive bad parity word causes SYNC→HUNT at the edge that samples it. A good parity word resets the error run to zero.
- R9: `src_en` low in SYNC causes SYNC→HUNT at the next clock edge. `user_stat` then reads "10" for every channel.
- R10: `dip_err` is high for exactly the one cycle after the edge that samples a bad parity word, and is low otherwise.
- R11: Asserting `rst_n` in SYNC forces the R1 outputs at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 1 | Allows synchronization; low forces HUNT |
| stat_in | input | 2 | Incoming status word, one per cycle |
| fifo_vld | input | 1 | Transmit FIFO has a word ready |
| fifo_data | input | DATA_W | Head word of the transmit FIFO |
| fifo_rd | output | 1 | Pop strobe for the transmit FIFO |
| tx_data | output | DATA_W | Transmit data bus |
| tx_kind | output | 2 | Bus content: 0 idle, 1 training, 2 data |
| user_stat | output | 2*NUM_CH | Per-channel flow control toward the user side |
| in_sync | output | 1 | High in SYNC |
| dip_err | output | 1 | One-cycle pulse per bad parity word |

## Verification
The assertions check the following on every cycle:
- entry into SYNC is always preceded by a good parity check with enable high;
- loss of enable, or four framing words in a row, always forces HUNT on the next cycle;
- RESET always leads to HUNT;
- a FIFO pop never happens outside SYNC;
- user status never changes in SYNC without a calendar write.

Only the bench scenarios can show the exact counting: that the match run resets on an error, that the error run resets on a match, and the boundary between three and four framing words. The same holds for the position of the training slots within the period, and for parity values computed from the rotation rule for chosen calendar contents.

// File: rtl/stat_sync_pkg.sv
package stat_sync_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_HUNT  = 2'd1,
        ST_SYNC  = 2'd2
    } sync_state_t;

    localparam logic [1:0] KIND_IDLE  = 2'd0;
    localparam logic [1:0] KIND_TRAIN = 2'd1;
    localparam logic [1:0] KIND_DATA  = 2'd2;

    localparam logic [1:0] FRAME_CODE = 2'b11;
    localparam logic [1:0] SATISFIED  = 2'b10;
    localparam logic [1:0] PAR_SEED   = 2'b11;

    // One step of the diagonal parity: rotate the 2-bit accumulator, fold in the word.
    function automatic logic [1:0] par_step(input logic [1:0] acc, input logic [1:0] word);
        return {acc[0], acc[1]} ^ word;
    endfunction

endpackage

// File: rtl/stat_sync_framer.sv
module stat_sync_framer
    import stat_sync_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int POS_W = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       stat_in,
    output logic             cal_we,
    output logic [POS_W-1:0] cal_idx,
    output logic [1:0]       cal_val,
    output logic             chk_valid,
    output logic             chk_ok,
    output logic             frame_err
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_CH);

    logic             prev_frame;
    logic             seq_active;
    logic [POS_W-1:0] pos;
    logic [1:0]       acc;
    logic [2:0]       frame_run;

    logic       cur_frame;
    logic       seq_start;
    logic       seq_cont;
    logic       seq_abort;
    logic       par_slot;
    logic [1:0] acc_next;

    always_comb begin
        cur_frame = (stat_in == FRAME_CODE);
        seq_start = !seq_active && prev_frame && !cur_frame;
        seq_cont  = seq_active && (pos < LAST_POS) && !cur_frame;
        seq_abort = seq_active && (pos < LAST_POS) && cur_frame;
        par_slot  = seq_active && (pos == LAST_POS);
        acc_next  = par_step(seq_start ? PAR_SEED : acc, stat_in);

        cal_we    = seq_start || seq_cont;
        cal_idx   = seq_start ? '0 : pos;
        cal_val   = stat_in;
        chk_valid = par_slot;
        chk_ok    = (stat_in == acc);
        frame_err = cur_frame && (frame_run == 3'd3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_frame <= 1'b0;
            seq_active <= 1'b0;
            pos        <= '0;
            acc        <= PAR_SEED;
            frame_run  <= '0;
        end else begin
            prev_frame <= cur_frame;
            if (seq_start) begin
                seq_active <= 1'b1;
                pos        <= POS_W'(1);
                acc        <= acc_next;
            end else if (seq_cont) begin
                pos        <= pos + POS_W'(1);
                acc        <= acc_next;
            end else if (seq_abort || par_slot) begin
                seq_active <= 1'b0;
            end
            if (!cur_frame)
                frame_run <= '0;
            else if (frame_run != 3'd4)
                frame_run <= frame_run + 3'd1;
        end
    end

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> (pos >= POS_W'(1) && pos <= LAST_POS)); // R4
    AST_CHECK_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $past(cal_we)); // R4

endmodule

// File: rtl/stat_sync_fsm.sv
module stat_sync_fsm
    import stat_sync_pkg::*;
#(
    parameter int MATCH_CNT = 2,
    parameter int ERR_CNT   = 2,
    localparam int CNT_MAX  = (MATCH_CNT > ERR_CNT) ? MATCH_CNT : ERR_CNT,
    localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_en,
    input  logic        chk_valid,
    input  logic        chk_ok,
    input  logic        frame_err,
    output sync_state_t state,
    output logic        dip_err
);

    sync_state_t      nxt;
    logic [CNT_W-1:0] match_cnt;
    logic [CNT_W-1:0] err_cnt;
    logic             cnt_clear;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET: nxt = ST_HUNT;
            ST_HUNT:  if (src_en && chk_valid && chk_ok &&
                          match_cnt == CNT_W'(MATCH_CNT - 1))
                          nxt = ST_SYNC;
            ST_SYNC:  if (!src_en || frame_err ||
                          (chk_valid && !chk_ok && err_cnt == CNT_W'(ERR_CNT - 1)))
                          nxt = ST_HUNT;
            default:  nxt = ST_RESET;
        endcase
        cnt_clear = (nxt != state) || (state == ST_RESET) ||
                    (state == ST_HUNT && !src_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_cnt <= '0;
            err_cnt   <= '0;
            dip_err   <= 1'b0;
        end else begin
            dip_err <= chk_valid && !chk_ok;
            if (cnt_clear) begin
                match_cnt <= '0;
                err_cnt   <= '0;
            end else if (chk_valid) begin
                if (chk_ok) begin
                    if (match_cnt != CNT_W'(CNT_MAX)) match_cnt <= match_cnt + CNT_W'(1);
                    err_cnt <= '0;
                end else begin
                    match_cnt <= '0;
                    if (err_cnt != CNT_W'(CNT_MAX)) err_cnt <= err_cnt + CNT_W'(1);
                end
            end
        end
    end

    AST_RESET_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |=> (state == ST_HUNT)); // R2
    AST_HUNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && !src_en) |=> (state != ST_SYNC)); // R3
    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SYNC) |-> $past(src_en && chk_valid && chk_ok)); // R4
    AST_FRAME_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && frame_err) |=> (state == ST_HUNT)); // R7
    AST_EN_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && !src_en) |=> (state == ST_HUNT)); // R9

endmodule

// File: rtl/stat_sync_txsel.sv
module stat_sync_txsel
    import stat_sync_pkg::*;
#(
    parameter int          DATA_W       = 16,
    parameter int          TRAIN_PERIOD = 8,
    parameter logic [15:0] IDLE_WORD    = 16'h0F0F,
    parameter logic [15:0] TRAIN_WORD   = 16'hF0F0,
    localparam int         TP_W         = (TRAIN_PERIOD > 1) ? $clog2(TRAIN_PERIOD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sync_state_t       state,
    input  logic              fifo_vld,
    input  logic [DATA_W-1:0] fifo_data,
    output logic [DATA_W-1:0] tx_data,
    output logic [1:0]        tx_kind,
    output logic              fifo_rd
);

    localparam logic [TP_W-1:0] SLOT_LAST = TP_W'(TRAIN_PERIOD - 1);

    logic [TP_W-1:0] slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  slot <= '0;
        else if (state != ST_SYNC)   slot <= '0;
        else if (slot == SLOT_LAST)  slot <= '0;
        else                         slot <= slot + TP_W'(1);
    end

    always_comb begin
        tx_data = DATA_W'(IDLE_WORD);
        tx_kind = KIND_IDLE;
        fifo_rd = 1'b0;
        unique case (state)
            ST_RESET: ;
            ST_HUNT: begin
                tx_data = DATA_W'(TRAIN_WORD);
                tx_kind = KIND_TRAIN;
            end
            ST_SYNC: begin
                if (slot == SLOT_LAST) begin
                    tx_data = DATA_W'(TRAIN_WORD);
                    tx_kind = KIND_TRAIN;
                end else if (fifo_vld) begin
                    tx_data = fifo_data;
                    tx_kind = KIND_DATA;
                    fifo_rd = 1'b1;
                end
            end
            default: ;
        endcase
    end

    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (state == ST_SYNC && fifo_vld)); // R6
    AST_TRAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && tx_kind == KIND_TRAIN) |=>
        (state != ST_SYNC || tx_kind != KIND_TRAIN)); // R6

endmodule

// File: rtl/stat_sync_ctrl.sv
module stat_sync_ctrl
    import stat_sync_pkg::*;
#(
    parameter int          NUM_CH       = 4,
    parameter int          MATCH_CNT    = 2,
    parameter int          ERR_CNT      = 2,
    parameter int          TRAIN_PERIOD = 8,
    parameter int          DATA_W       = 16,
    parameter logic [15:0] IDLE_WORD    = 16'h0F0F,
    parameter logic [15:0] TRAIN_WORD   = 16'hF0F0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_en,
    input  logic [1:0]          stat_in,
    input  logic                fifo_vld,
    input  logic [DATA_W-1:0]   fifo_data,
    output logic                fifo_rd,
    output logic [DATA_W-1:0]   tx_data,
    output logic [1:0]          tx_kind,
    output logic [2*NUM_CH-1:0] user_stat,
    output logic                in_sync,
    output logic                dip_err
);

    localparam int POS_W = $clog2(NUM_CH + 1);

    sync_state_t      state;
    logic             cal_we;
    logic [POS_W-1:0] cal_idx;
    logic [1:0]       cal_val;
    logic             chk_valid;
    logic             chk_ok;
    logic             frame_err;
    logic [2*NUM_CH-1:0] stat_q;

    stat_sync_framer #(.NUM_CH(NUM_CH)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_in   (stat_in),
        .cal_we    (cal_we),
        .cal_idx   (cal_idx),
        .cal_val   (cal_val),
        .chk_valid (chk_valid),
        .chk_ok    (chk_ok),
        .frame_err (frame_err)
    );

    stat_sync_fsm #(.MATCH_CNT(MATCH_CNT), .ERR_CNT(ERR_CNT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .chk_valid (chk_valid),
        .chk_ok    (chk_ok),
        .frame_err (frame_err),
        .state     (state),
        .dip_err   (dip_err)
    );

    stat_sync_txsel #(
        .DATA_W       (DATA_W),
        .TRAIN_PERIOD (TRAIN_PERIOD),
        .IDLE_WORD    (IDLE_WORD),
        .TRAIN_WORD   (TRAIN_WORD)
    ) u_txsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .fifo_vld  (fifo_vld),
        .fifo_data (fifo_data),
        .tx_data   (tx_data),
        .tx_kind   (tx_kind),
        .fifo_rd   (fifo_rd)
    );

    // Per-channel flow-control holding registers, live only in SYNC.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_q[2*k +: 2] <= SATISFIED;
            else if (state != ST_SYNC)
                stat_q[2*k +: 2] <= SATISFIED;
            else if (cal_we && cal_idx == POS_W'(k))
                stat_q[2*k +: 2] <= cal_val;
        end
    end

    always_comb begin
        in_sync   = (state == ST_SYNC);
        user_stat = in_sync ? stat_q : {NUM_CH{SATISFIED}};
    end

    AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && $past(in_sync) && !$past(cal_we)) |-> $stable(user_stat)); // R5

endmodule

// File: tb/stat_sync_ctrl_bench.sv
`timescale 1ns/100ps
module stat_sync_ctrl_bench;

    localparam int          NUM_CH = 4;
    localparam int          TP     = 8;
    localparam logic [15:0] IDLE_W = 16'h0F0F;
    localparam logic [15:0] TRN_W  = 16'hF0F0;

    // {en, calendar[7:0] (ch0 in [1:0]), good parity, expected in_sync after parity word}
    localparam logic [10:0] VEC [10] = '{
        {1'b1, 8'h24, 1'b1, 1'b0},  // first good check
        {1'b1, 8'h19, 1'b1, 1'b1},  // second good check -> SYNC
        {1'b1, 8'h86, 1'b0, 1'b1},  // one error, hold
        {1'b1, 8'h00, 1'b1, 1'b1},  // good clears error run
        {1'b1, 8'h66, 1'b0, 1'b1},  // one error again
        {1'b1, 8'hAA, 1'b0, 1'b0},  // second consecutive error -> HUNT
        {1'b1, 8'h11, 1'b1, 1'b0},  // match run 1
        {1'b1, 8'h44, 1'b0, 1'b0},  // error clears match run
        {1'b1, 8'h99, 1'b1, 1'b0},  // match run 1
        {1'b1, 8'h22, 1'b1, 1'b1}   // match run 2 -> SYNC
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_en = 1'b0;
    logic [1:0]  stat_in = 2'b11;
    logic        fifo_vld = 1'b1;
    logic [15:0] fifo_data = 16'h1234;
    logic        fifo_rd;
    logic [15:0] tx_data;
    logic [1:0]  tx_kind;
    logic [7:0]  user_stat;
    logic        in_sync;
    logic        dip_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sync_cyc = 0;
    logic post_rst;

    always #2 clk = ~clk;

    stat_sync_ctrl #(
        .NUM_CH(NUM_CH), .MATCH_CNT(2), .ERR_CNT(2), .TRAIN_PERIOD(TP),
        .DATA_W(16), .IDLE_WORD(IDLE_W), .TRAIN_WORD(TRN_W)
    ) u_stat_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .stat_in(stat_in),
        .fifo_vld(fifo_vld), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .tx_data(tx_data), .tx_kind(tx_kind), .user_stat(user_stat),
        .in_sync(in_sync), .dip_err(dip_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [1:0] w);
        @(negedge clk);
        stat_in = w;
        @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input logic en, input logic [7:0] cal, input logic good,
                           input logic exp_sync, input string tag);
        logic [1:0] a;
        logic       sb;
        src_en = en;
        send_word(2'b11);
        sb = in_sync;
        a = 2'b11;
        for (int k = 0; k < NUM_CH; k++) begin
            a = {a[0], a[1]} ^ cal[2*k +: 2];
            send_word(cal[2*k +: 2]);
        end
        chk(32'(user_stat), sb ? 32'(cal) : 32'hAA, "R5 user status after calendar");
        send_word(good ? a : (a ^ 2'b01));
        chk(32'(in_sync), 32'(exp_sync), tag);
        chk(32'(dip_err), 32'(!good), "R10 parity error pulse");
        send_word(2'b11);
        chk(32'(dip_err), 32'h0, "R10 pulse lasts one cycle");
    endtask

    always @(posedge clk) fifo_data <= fifo_data + 16'h0103;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) post_rst <= 1'b0;
        else        post_rst <= 1'b1;

    // Per-cycle model of the transmit bus.
    always @(negedge clk) begin
        if (!post_rst) begin
            chk(32'(tx_kind), 32'h0, "R1 idle kind in reset");
            chk(32'(tx_data), 32'(IDLE_W), "R1 idle word in reset");
            sync_cyc = 0;
        end else if (in_sync) begin
            if (sync_cyc == TP - 1) begin
                chk(32'(tx_kind), 32'h1, "R6 training slot");
                chk(32'(tx_data), 32'(TRN_W), "R6 training word");
                chk(32'(fifo_rd), 32'h0, "R6 no pop in training slot");
                sync_cyc = 0;
            end else begin
                chk(32'(tx_kind), 32'h2, "R6 data slot");
                chk(32'(tx_data), 32'(fifo_data), "R6 data passthrough");
                chk(32'(fifo_rd), 32'h1, "R6 pop in data slot");
                sync_cyc = sync_cyc + 1;
            end
        end else begin
            chk(32'(tx_kind), 32'h1, "R2 training in hunt");
            chk(32'(tx_data), 32'(TRN_W), "R2 training word in hunt");
            chk(32'(fifo_rd), 32'h0, "R2 no pop in hunt");
            sync_cyc = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(32'(in_sync), 32'h0, "R1 not in sync during reset");
        chk(32'(user_stat), 32'hAA, "R1 satisfied during reset");
        chk(32'(fifo_rd), 32'h0, "R1 no pop during reset");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(32'(tx_kind), 32'h1, "R2 hunt after release");
        chk(32'(user_stat), 32'hAA, "R2 satisfied in hunt");

        for (int i = 0; i < 10; i++)
            run_seq(VEC[i][10], VEC[i][9:2], VEC[i][1], VEC[i][0], "R4 R8 table in_sync");

        // Framing loss: DIP of 8'h04 is 2'b10, so the run starts at the trailing framing word.
        run_seq(1'b1, 8'h04, 1'b1, 1'b1, "R5 stay in sync");
        send_word(2'b11);
        send_word(2'b11);
        chk(32'(in_sync), 32'h1, "R7 three framing words keep sync");
        send_word(2'b11);
        chk(32'(in_sync), 32'h0, "R7 fourth framing word drops sync");
        chk(32'(user_stat), 32'hAA, "R2 satisfied after loss");

        run_seq(1'b1, 8'h24, 1'b1, 1'b0, "R4 regain first");
        run_seq(1'b1, 8'h19, 1'b1, 1'b1, "R4 regain second");

        @(negedge clk);
        src_en = 1'b0;
        @(posedge clk);
        #1;
        chk(32'(in_sync), 32'h0, "R9 enable low leaves sync");
        chk(32'(user_stat), 32'hAA, "R9 satisfied after enable loss");

        run_seq(1'b0, 8'h24, 1'b1, 1'b0, "R3 disabled no sync");
        run_seq(1'b0, 8'h19, 1'b1, 1'b0, "R3 disabled no sync");
        run_seq(1'b0, 8'h86, 1'b1, 1'b0, "R3 disabled no sync");
        run_seq(1'b1, 8'h00, 1'b1, 1'b0, "R3 count restarts at enable");
        run_seq(1'b1, 8'h66, 1'b1, 1'b1, "R4 sync after re-enable");

        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        chk(32'(in_sync), 32'h0, "R11 reset leaves sync at once");
        chk(32'(tx_kind), 32'h0, "R11 idle at once");
        chk(32'(tx_data), 32'(IDLE_W), "R11 idle word at once");
        chk(32'(user_stat), 32'hAA, "R11 satisfied at once");
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(32'(tx_kind), 32'h1, "R2 hunt after second release");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule